// File: doc/BRIEF.md
# Pipelined Dot-Product Reduce and Requantize

This block is the back end of a matrix-vector datapath. Each clock it may take a vector of 32 signed partial products, one weight column's worth. It sums the vector to one scalar through a five-level registered pair-sum tree and adds that scalar into a running row total. When a column arrives marked as the last of its row, the finished row total is scaled by a weight factor and an activation factor, offset by a bias, rounded and clamped to a signed 8-bit result.

The scale, bias and destination of a row are taken from side inputs on the cycle its last column is accepted. They travel down the pipeline with that column, so the next row's settings may be applied at once. Each result comes out as a single strobe. One strobe feeds a memory write port and the other feeds a direct FIFO toward a special-function unit, and the destination bit picks which one fires.

Top module: `dp_reduce_rq`

## Requirements
- R1: `prod_vec` carries 32 signed 20-bit products, product i at bits [20*i+19 : 20*i]. The tree sums all 32 exactly, covering the full range from 32 × (-2^19) to 32 × (2^19 - 1). The first level adds products 2i and 2i+1.
- R2: A new product vector can be accepted on every clock, so single-column rows may follow each other with no gap, and each row yields its own result.
- R3: A result strobe rises exactly 6 clock edges after the edge that samples a valid last column: five tree registers, one accumulator register and one output register.
- R4: The row total is the sum of all valid columns since the previous last column. The accumulator is empty again for the column that follows a last column.
- R5: A cycle with `prod_vld` low is ignored, whatever `prod_vec`, `col_last` and the side inputs hold. It changes no row total and produces no strobe.
- R6: The pre-rounding value is total × wscale × ascale / 2^16 + bias. The scales are unsigned 16-bit values with 8 fractional bits, and the bias is a signed 32-bit integer added after scaling.
- R7: Rounding to an integer is half away from zero, so +0.5 becomes 1, -0.5 becomes -1 and 1.5 becomes 2.
- R8: Results above 127 give 127 and results below -128 give -128.
- R9: With `dst_sel` = 0 (memory) only `mem_we` pulses, and with `dst_sel` = 1 (FIFO) only `fifo_push` pulses. Each pulse lasts one cycle per row, and the two never fire together.
- R10: The scale, bias and destination in effect for a row are those present on the cycle its last column is accepted. Their values on any other cycle have no effect on that row.
- R11: While `rst_n` is low and right after it, `mem_we`, `fifo_push` and `res_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_vld | input | 1 | Product vector valid |
| col_last | input | 1 | This column closes the row |
| prod_vec | input | 640 | 32 signed 20-bit partial products |
| wscale | input | 16 | Weight scale, unsigned Q8.8 |
| ascale | input | 16 | Activation scale, unsigned Q8.8 |
| bias | input | 32 | Signed integer bias |
| dst_sel | input | 1 | 0 memory port, 1 FIFO port |
| res_q | output | 8 | Signed INT8 result |
| mem_we | output | 1 | Result strobe toward memory |
| fifo_push | output | 1 | Result strobe toward the FIFO |

## Verification
A row's result is due on the sixth rising edge after the edge that samples its last column. Bubbles and earlier columns do not move that deadline. The bench drives inputs on falling edges and notes the cycle count whenever it queues an expected result, with the due cycle set to that count plus seven. The monitor samples on falling edges, and every strobe it sees must match the head of the queue in value, in destination and in the exact cycle it arrives.

// File: rtl/dp_reduce_rq_pkg.sv
package dp_reduce_rq_pkg;
  typedef enum logic {
    DST_MEM  = 1'b0,
    DST_FIFO = 1'b1
  } dst_e;
endpackage

// File: rtl/dp_pair_tree.sv
module dp_pair_tree #(
  parameter int N     = 32,
  parameter int IN_W  = 20,
  parameter int TAG_W = 1,
  parameter int OUT_W = IN_W + $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [N*IN_W-1:0]      in_vec,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   out_vld,
  output logic signed [OUT_W-1:0] out_sum,
  output logic [TAG_W-1:0]       out_tag
);
  localparam int LVL = $clog2(N);

  for (genvar s = 0; s < LVL; s++) begin : g_lvl
    localparam int CNT = N >> (s + 1);
    localparam int OW  = IN_W + s + 1;
    logic signed [OW-1:0] sum_q [CNT];
    logic                 vld_q;
    logic [TAG_W-1:0]     tag_q;

    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        for (int i = 0; i < CNT; i++)
          sum_q[i] <= OW'($signed(in_vec[2*i*IN_W +: IN_W]))
                    + OW'($signed(in_vec[(2*i+1)*IN_W +: IN_W]));
        tag_q <= in_tag;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_vld;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        for (int i = 0; i < CNT; i++)
          sum_q[i] <= OW'(g_lvl[s-1].sum_q[2*i]) + OW'(g_lvl[s-1].sum_q[2*i+1]);
        tag_q <= g_lvl[s-1].tag_q;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= g_lvl[s-1].vld_q;
      end
    end
  end

  assign out_vld = g_lvl[LVL-1].vld_q;
  assign out_sum = g_lvl[LVL-1].sum_q[0];
  assign out_tag = g_lvl[LVL-1].tag_q;

  // in-flight count: entries minus exits can never exceed the tree depth
  logic [7:0] inflight_q;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + 8'(in_vld) - 8'(out_vld);
  end

  assert_tree_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= 8'(LVL));
endmodule

// File: rtl/dp_row_acc.sv
module dp_row_acc #(
  parameter int IN_W   = 25,
  parameter int ACC_W  = 32,
  parameter int META_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    in_last,
  input  logic signed [IN_W-1:0]  in_val,
  input  logic [META_W-1:0]       in_meta,
  output logic                    row_vld,
  output logic signed [ACC_W-1:0] row_sum,
  output logic [META_W-1:0]       row_meta
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt_w;
  logic                    close_w;

  assign acc_nxt_w = acc_q + ACC_W'(in_val);
  assign close_w   = in_vld && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      row_vld  <= 1'b0;
      row_sum  <= '0;
      row_meta <= '0;
    end else begin
      row_vld <= close_w;
      if (close_w) begin
        acc_q    <= '0;
        row_sum  <= acc_nxt_w;
        row_meta <= in_meta;
      end else if (in_vld) begin
        acc_q <= acc_nxt_w;
      end
    end
  end

  assert_bubble_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(acc_q));
  assert_row_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    close_w |=> (acc_q == '0));
endmodule

// File: rtl/dp_requant.sv
module dp_requant #(
  parameter int ACC_W  = 32,
  parameter int SC_W   = 16,
  parameter int FRAC   = 8,
  parameter int BIAS_W = 32,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_vld,
  input  logic signed [ACC_W-1:0]  row_sum,
  input  logic [SC_W-1:0]          wsc,
  input  logic [SC_W-1:0]          asc,
  input  logic signed [BIAS_W-1:0] rbias,
  input  logic                     dst,
  output logic signed [OUT_W-1:0]  res_q,
  output logic                     mem_we,
  output logic                     fifo_push
);
  import dp_reduce_rq_pkg::*;

  localparam int PW   = ACC_W + 2*SC_W + 4;
  localparam int SH   = 2 * FRAC;
  localparam int MAXP = 2**(OUT_W-1) - 1;

  // total * wsc * asc with 2*FRAC fraction bits, plus the bias aligned to it
  function automatic logic signed [PW-1:0] scale_bias(
    input logic signed [ACC_W-1:0] t, input logic [SC_W-1:0] w,
    input logic [SC_W-1:0] a, input logic signed [BIAS_W-1:0] b);
    logic signed [PW-1:0] p;
    p = PW'(t) * PW'($signed({1'b0, w})) * PW'($signed({1'b0, a}));
    return p + (PW'(b) <<< SH);
  endfunction

  // magnitude rounded half up, i.e. half away from zero once the sign returns
  function automatic logic [PW-1:0] round_mag(input logic signed [PW-1:0] v);
    logic [PW-1:0] m;
    m = v[PW-1] ? PW'(-v) : PW'(v);
    return (m + (PW'(1) << (SH - 1))) >> SH;
  endfunction

  logic signed [PW-1:0]    pre_w;
  logic                    neg_w;
  logic [PW-1:0]           mag_w;
  logic                    sat_hi_w, sat_lo_w;
  logic signed [OUT_W-1:0] res_w;

  always_comb begin
    pre_w    = scale_bias(row_sum, wsc, asc, rbias);
    neg_w    = pre_w[PW-1];
    mag_w    = round_mag(pre_w);
    sat_hi_w = !neg_w && (mag_w > PW'(MAXP));
    sat_lo_w =  neg_w && (mag_w > PW'(MAXP + 1));
    if (sat_hi_w)      res_w = OUT_W'(MAXP);
    else if (sat_lo_w) res_w = OUT_W'(-(MAXP + 1));
    else if (neg_w)    res_w = OUT_W'(-mag_w);
    else               res_w = OUT_W'(mag_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      mem_we    <= 1'b0;
      fifo_push <= 1'b0;
    end else begin
      mem_we    <= row_vld && (dst_e'(dst) == DST_MEM);
      fifo_push <= row_vld && (dst_e'(dst) == DST_FIFO);
      if (row_vld) res_q <= res_w;
    end
  end

  assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, fifo_push}));
  assert_row_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |=> (mem_we || fifo_push));
  assert_clamp_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_vld && sat_hi_w) |=> (res_q == OUT_W'(MAXP)));
  assert_clamp_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_vld && sat_lo_w) |=> (res_q == OUT_W'(-(MAXP + 1))));
endmodule

// File: rtl/dp_reduce_rq.sv
module dp_reduce_rq #(
  parameter int N_IN   = 32,
  parameter int IN_W   = 20,
  parameter int ACC_W  = 32,
  parameter int SC_W   = 16,
  parameter int FRAC   = 8,
  parameter int BIAS_W = 32,
  parameter int OUT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prod_vld,
  input  logic                    col_last,
  input  logic [N_IN*IN_W-1:0]    prod_vec,
  input  logic [SC_W-1:0]         wscale,
  input  logic [SC_W-1:0]         ascale,
  input  logic [BIAS_W-1:0]       bias,
  input  logic                    dst_sel,
  output logic [OUT_W-1:0]        res_q,
  output logic                    mem_we,
  output logic                    fifo_push
);
  localparam int TREE_W = IN_W + $clog2(N_IN);
  localparam int META_W = 2*SC_W + BIAS_W + 1;
  localparam int TAG_W  = META_W + 1;

  logic [TAG_W-1:0]         in_tag_w, t_tag_w;
  logic                     t_vld_w;
  logic signed [TREE_W-1:0] t_sum_w;
  logic                     r_vld_w;
  logic signed [ACC_W-1:0]  r_sum_w;
  logic [META_W-1:0]        r_meta_w;
  logic signed [OUT_W-1:0]  res_w;

  // row settings ride with the column so a closing column carries its own
  assign in_tag_w = {col_last, dst_sel, bias, ascale, wscale};

  dp_pair_tree #(.N(N_IN), .IN_W(IN_W), .TAG_W(TAG_W), .OUT_W(TREE_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .in_vld(prod_vld), .in_vec(prod_vec), .in_tag(in_tag_w),
    .out_vld(t_vld_w), .out_sum(t_sum_w), .out_tag(t_tag_w));

  dp_row_acc #(.IN_W(TREE_W), .ACC_W(ACC_W), .META_W(META_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_vld(t_vld_w), .in_last(t_tag_w[TAG_W-1]),
    .in_val(t_sum_w), .in_meta(t_tag_w[META_W-1:0]),
    .row_vld(r_vld_w), .row_sum(r_sum_w), .row_meta(r_meta_w));

  dp_requant #(.ACC_W(ACC_W), .SC_W(SC_W), .FRAC(FRAC), .BIAS_W(BIAS_W), .OUT_W(OUT_W)) u_rq (
    .clk(clk), .rst_n(rst_n), .row_vld(r_vld_w), .row_sum(r_sum_w),
    .wsc(r_meta_w[SC_W-1:0]), .asc(r_meta_w[2*SC_W-1:SC_W]),
    .rbias($signed(r_meta_w[2*SC_W+BIAS_W-1:2*SC_W])), .dst(r_meta_w[META_W-1]),
    .res_q(res_w), .mem_we(mem_we), .fifo_push(fifo_push));

  assign res_q = res_w;
endmodule

// File: tb/dp_reduce_rq_tb.sv
module dp_reduce_rq_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         prod_vld, col_last, dst_sel;
  logic [639:0] prod_vec;
  logic [15:0]  wscale, ascale;
  logic [31:0]  bias;
  logic [7:0]   res_q;
  logic         mem_we, fifo_push;

  always #5 clk = ~clk;

  dp_reduce_rq u_dut (
    .clk(clk), .rst_n(rst_n), .prod_vld(prod_vld), .col_last(col_last),
    .prod_vec(prod_vec), .wscale(wscale), .ascale(ascale), .bias(bias),
    .dst_sel(dst_sel), .res_q(res_q), .mem_we(mem_we), .fifo_push(fifo_push));

  int     n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  int     cur [32];
  longint row_acc = 0;

  int     q_data [$];
  bit     q_dest [$];
  longint q_due  [$];
  string  q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expect_q(longint t, int ws, int asc, int b);
    longint v, q;
    v = t * ws * asc + longint'(b) * 65536;
    if (v >= 0) q = (v + 32768) / 65536;
    else        q = -((-v + 32768) / 65536);
    if (q > 127)  q = 127;
    if (q < -128) q = -128;
    return int'(q);
  endfunction

  task automatic clr();
    for (int i = 0; i < 32; i++) cur[i] = 0;
  endtask

  task automatic junk_side();
    wscale  = 16'($urandom);
    ascale  = 16'($urandom);
    bias    = $urandom;
    dst_sel = 1'($urandom);
  endtask

  // one valid column; on a closing column the expected result is queued
  task automatic col(input bit last, input int ws, input int asc, input int b,
                     input bit dst, input string tag);
    @(negedge clk);
    prod_vld = 1'b1;
    col_last = last;
    for (int i = 0; i < 32; i++) begin
      prod_vec[i*20 +: 20] = cur[i][19:0];
      row_acc += cur[i];
    end
    if (last) begin
      wscale = 16'(ws); ascale = 16'(asc); bias = b; dst_sel = dst;
      q_data.push_back(expect_q(row_acc, ws, asc, b));
      q_dest.push_back(dst);
      q_due.push_back(cyc + 7);
      q_tag.push_back(tag);
      row_acc = 0;
    end else begin
      junk_side(); // R10: settings off the closing cycle are noise
    end
  endtask

  task automatic bubble();
    @(negedge clk);
    prod_vld = 1'b0;
    col_last = 1'b1;
    for (int i = 0; i < 20; i++) prod_vec[i*32 +: 32] = $urandom;
    junk_side(); // R5: nothing here may reach a row
  endtask

  task automatic single(input int v, input int ws, input int asc, input int b,
                        input bit dst, input string tag);
    clr(); cur[0] = v;
    col(1'b1, ws, asc, b, dst, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (mem_we || fifo_push)) begin
      n_cmp++;
      if (mem_we && fifo_push) begin
        n_bad++; $display("FAIL R9: both strobes high, actual 11 expected one");
      end else if (q_data.size() == 0) begin
        n_bad++; $display("FAIL R5: unexpected result %0d, expected none", $signed(res_q));
      end else begin
        int     ed; bit ex; longint due; string tg;
        ed = q_data.pop_front(); ex = q_dest.pop_front();
        due = q_due.pop_front(); tg = q_tag.pop_front();
        if ($signed(res_q) != ed) begin
          n_bad++; $display("FAIL %s: result actual %0d expected %0d", tg, $signed(res_q), ed);
        end else if (fifo_push != ex) begin
          n_bad++; $display("FAIL R9 (%s): fifo strobe actual %0b expected %0b", tg, fifo_push, ex);
        end else if (cyc != due) begin
          n_bad++; $display("FAIL R3 (%s): cycle actual %0d expected %0d", tg, cyc, due);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; prod_vld = 1'b0; col_last = 1'b0; prod_vec = '0;
    wscale = '0; ascale = '0; bias = '0; dst_sel = 1'b0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({mem_we, fifo_push, res_q} !== 10'd0) begin
      n_bad++; $display("FAIL R11: in reset actual %0h expected 0", {mem_we, fifo_push, res_q});
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if ({mem_we, fifo_push, res_q} !== 10'd0) begin
      n_bad++; $display("FAIL R11: after reset actual %0h expected 0", {mem_we, fifo_push, res_q});
    end

    // R1: ramp of mixed signs, then both extremes of the product range
    clr(); for (int i = 0; i < 32; i++) cur[i] = i * 1000 - 15000;
    col(1'b1, 1, 256, 0, 1'b0, "R1 ramp");
    clr(); for (int i = 0; i < 32; i++) cur[i] = 524287;
    col(1'b1, 1, 1, -255, 1'b0, "R1 max");
    clr(); for (int i = 0; i < 32; i++) cur[i] = -524288;
    col(1'b1, 1, 1, 257, 1'b1, "R1 min");
    clr(); cur[6] = 40; cur[7] = -1; // pair 2i,2i+1
    col(1'b1, 256, 256, 0, 1'b0, "R1 pair");

    // R4 + R5: four columns with noisy bubbles between them
    for (int c = 0; c < 4; c++) begin
      clr(); cur[c] = 5 + c; cur[31-c] = -2;
      col(c == 3, 256, 256, -30, 1'b1, "R4 multi-col");
      bubble();
    end
    single(9, 256, 256, 0, 1'b0, "R4 cleared");
    repeat (3) bubble();

    // R2 + R9: back-to-back single-column rows, alternating ports
    for (int k = 0; k < 8; k++) begin
      clr(); for (int i = 0; i < 32; i++) cur[i] = (i % 4) * (k - 3);
      col(1'b1, 256, 128, k, k[0], "R2 back-to-back");
    end

    // R7 rounding
    single(1, 256, 128, 0, 1'b0, "R7 +0.5");
    single(-1, 256, 128, 0, 1'b1, "R7 -0.5");
    single(3, 256, 128, 0, 1'b0, "R7 1.5");
    single(-3, 256, 128, 0, 1'b0, "R7 -1.5");
    single(7, 64, 64, 0, 1'b1, "R7 0.4375");
    single(8, 64, 64, 0, 1'b0, "R7 0.5 small");
    single(-8, 64, 64, 0, 1'b0, "R7 -0.5 small");

    // R8 saturation
    single(1000, 256, 256, 0, 1'b0, "R8 high");
    single(-1000, 256, 256, 0, 1'b1, "R8 low");
    single(100, 256, 256, 100, 1'b0, "R8 bias high");
    single(127, 256, 256, 0, 1'b0, "R8 127");
    single(128, 256, 256, 0, 1'b0, "R8 128");
    single(-128, 256, 256, 0, 1'b1, "R8 -128");
    single(-129, 256, 256, 0, 1'b0, "R8 -129");

    // R6 scale then bias
    single(300, 512, 32, -20, 1'b0, "R6 scale");
    single(-50, 384, 256, 3, 1'b1, "R6 frac scale");

    // R10: settings change right after the closing column
    single(20, 256, 256, 1, 1'b1, "R10 latch");
    repeat (4) bubble();

    @(negedge clk); prod_vld = 1'b0; col_last = 1'b0;
    repeat (12) @(negedge clk);
    n_cmp++;
    if (q_data.size() != 0) begin
      n_bad++; $display("FAIL R5: pending results actual %0d expected 0", q_data.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule